// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of pulsed peripheral interrupt requests and four non-maskable trap requests, chooses one winner, and offers it to the CPU as a single request with a 4-bit level and a word vector address. Each peripheral source carries a 3-bit programmable level. Arbitration runs in two steps: the highest programmed level wins first, and the lowest source index breaks any tie at that level. Traps always rank above peripheral sources.

The block also holds the CPU priority level. A request is offered only when its level is strictly above that level. When the CPU accepts a request, the controller saves the current level on a small nesting stack and raises the level to that of the winner. A return handshake pops the saved level back. Software can write the level through its own port, within the limits given below. A control register selects between two vector tables and can lock the lower level bits.

Top module: `prio_vec_ctrl`

## Requirements
- R1: After reset the CPU level is 0, no request is offered, the alternate table is off, nesting is enabled, nothing is pending, and every source priority is 4.
- R2: A request is offered only when the winner's level is strictly greater than the CPU level. A source with priority 0 is never offered.
- R3: Among pending sources, the highest programmed priority wins. At equal priority, the lowest source index wins.
- R4: The vector for source k is 0x14 + 2k. The vector for trap number n is 0x04 + 2n. With the alternate-table bit set, 0x100 is added to every vector.
- R5: The traps are oscillator failure (trap_req bit 0, number 1, level 14), address error (bit 1, number 2, level 13), stack error (bit 2, number 3, level 12) and arithmetic error (bit 3, number 4, level 11). Any pending trap beats every peripheral source, and a trap with a lower number beats one with a higher number.
- R6: A peripheral pulse or a hard trap pulse (bits 0 and 1) is pending after one clock edge. A soft trap pulse (bits 2 and 3) is pending only after two clock edges.
- R7: An ack while a request is offered clears that winner's pending flag, pushes the CPU level, and sets the CPU level to the winner's level on the next cycle. An ack while no request is offered has no effect.
- R8: A ret pops the saved level into the CPU level. A ret with an empty stack has no effect. If ret and ack arrive together, only the ret is performed.
- R9: While the nesting stack holds NEST entries, no request is offered.
- R10: A level write cannot set bit 3 but can clear it. While nesting is disabled, bits 2:0 keep their value. An ack or a ret in the same cycle takes precedence over a level write.
- R11: A config write to an address below NSRC sets that source's priority from cfg_wdata[2:0]. A write to address NSRC sets the alternate-table bit from bit 0 and nest-disable from bit 1. Writes to higher addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NSRC | Peripheral request pulses |
| trap_req | input | 4 | Trap request pulses (bit 0 oscillator, 1 address, 2 stack, 3 arithmetic) |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | $clog2(NSRC+1) | Config address: source index, or NSRC for control |
| cfg_wdata | input | 3 | Config write data |
| lvl_we | input | 1 | CPU level write strobe |
| lvl_wdata | input | 4 | CPU level write data |
| ack | input | 1 | CPU accepts the offered request |
| ret | input | 1 | CPU returns from the current service |
| cpu_lvl | output | 4 | Current CPU priority level |
| req_valid | output | 1 | A request is offered |
| req_lvl | output | 4 | Level of the offered winner |
| req_vector | output | VW | Vector word address of the winner |

## Verification
The bench builds the block with NSRC = 8 and NEST = 2. With only eight sources, a single mask byte covers every tie and override case of the two-step arbitration. A depth of two fills the nesting stack after two accepted requests, so the full-stack block and the pop order can both be reached within a short directed sequence. The directed tests cover both vector tables, the one-cycle and two-cycle trap sampling paths, and the rules on level writes.

// File: rtl/prio_vec_ctrl.sv
module prio_vec_ctrl #(
  parameter int NSRC     = 16,
  parameter int NEST     = 4,
  parameter int VW       = 24,
  parameter int RST_PRIO = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           irq_req,
  input  logic [3:0]                trap_req,
  input  logic                      cfg_we,
  input  logic [$clog2(NSRC+1)-1:0] cfg_addr,
  input  logic [2:0]                cfg_wdata,
  input  logic                      lvl_we,
  input  logic [3:0]                lvl_wdata,
  input  logic                      ack,
  input  logic                      ret,
  output logic [3:0]                cpu_lvl,
  output logic                      req_valid,
  output logic [3:0]                req_lvl,
  output logic [VW-1:0]             req_vector
);
  localparam int AW  = $clog2(NSRC+1);
  localparam int KW  = $clog2(NSRC);
  localparam int SPW = $clog2(NEST+1);
  localparam int IW  = $clog2(NEST);

  logic [2:0]      prio [NSRC];
  logic [NSRC-1:0] pend;
  logic [3:0]      tpend;
  logic [1:0]      soft_s1;
  logic            alt, nest_dis;
  logic [3:0]      stk [NEST];
  logic [SPW-1:0]  sp;

  logic [2:0]      best_lvl;
  logic [KW-1:0]   best_k;
  logic [1:0]      tsel;
  logic            trap_any, full, take, pop;

  always_comb begin
    best_lvl = '0;
    best_k   = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend[i] && prio[i] > best_lvl) begin
        best_lvl = prio[i];
        best_k   = KW'(i);
      end
  end

  assign tsel     = tpend[0] ? 2'd0 : tpend[1] ? 2'd1 : tpend[2] ? 2'd2 : 2'd3;
  assign trap_any = |tpend;
  assign full     = (sp == SPW'(NEST));
  assign req_lvl  = trap_any ? 4'd14 - {2'b0, tsel} : {1'b0, best_lvl};
  assign req_valid = (req_lvl > cpu_lvl) && !full;
  assign req_vector = (alt ? VW'(12'h104) : VW'(12'h004)) +
                      (trap_any ? VW'({tsel, 1'b0}) + VW'(2)
                                : VW'(8'h10) + VW'({best_k, 1'b0}));
  assign pop  = ret && (sp != '0);
  assign take = ack && !ret && req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) prio[i] <= 3'(RST_PRIO);
      alt      <= 1'b0;
      nest_dis <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr < AW'(NSRC)) prio[cfg_addr[KW-1:0]] <= cfg_wdata;
      else if (cfg_addr == AW'(NSRC)) begin
        alt      <= cfg_wdata[0];
        nest_dis <= cfg_wdata[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      tpend   <= '0;
      soft_s1 <= '0;
    end else begin
      soft_s1 <= trap_req[3:2];
      pend    <= (pend & ~((take && !trap_any) ? (NSRC'(1) << best_k) : '0)) | irq_req;
      tpend   <= (tpend & ~((take && trap_any) ? (4'b1 << tsel) : 4'b0)) |
                 {soft_s1, trap_req[1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_lvl <= '0;
      sp      <= '0;
      for (int i = 0; i < NEST; i++) stk[i] <= '0;
    end else if (ret) begin
      if (pop) begin
        cpu_lvl <= stk[IW'(sp - 1'b1)];
        sp      <= sp - 1'b1;
      end
    end else if (take) begin
      stk[IW'(sp)] <= cpu_lvl;
      sp           <= sp + 1'b1;
      cpu_lvl      <= req_lvl;
    end else if (lvl_we) begin
      cpu_lvl[3]   <= cpu_lvl[3] & lvl_wdata[3];
      if (!nest_dis) cpu_lvl[2:0] <= lvl_wdata[2:0];
    end
  end

  assert_offer_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_lvl != 4'd0) && (sp < SPW'(NEST)));
  assert_ack_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ret && req_valid) |=> (cpu_lvl == $past(req_lvl)) && (sp == $past(sp) + 1'b1));
  assert_ret_pops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && sp != '0) |=> (sp == $past(sp) - 1'b1));
  assert_stack_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(NEST));
  assert_bit3_no_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_we && !ack && !ret && !cpu_lvl[3]) |=> !cpu_lvl[3]);
  assert_trap_rank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_any) |-> (req_lvl >= 4'd11));
  assert_alt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == AW'(NSRC)) |=> $stable(alt));
endmodule

// File: tb/test_prio_vec_ctrl.sv
module test_prio_vec_ctrl;
  localparam int CLK_P = 10;
  localparam int NSRC  = 8;
  localparam int NEST  = 2;
  localparam int VW    = 24;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] irq_req = '0;
  logic [3:0] trap_req = '0, lvl_wdata = '0;
  logic cfg_we = 0, lvl_we = 0, ack = 0, ret = 0;
  logic [3:0] cfg_addr = '0;
  logic [2:0] cfg_wdata = '0;
  logic [3:0] cpu_lvl, req_lvl;
  logic req_valid;
  logic [VW-1:0] req_vector;
  int checks = 0, fails = 0;

  prio_vec_ctrl #(.NSRC(NSRC), .NEST(NEST), .VW(VW)) i_prio_vec_ctrl (
    .clk, .rst_n, .irq_req, .trap_req, .cfg_we, .cfg_addr, .cfg_wdata,
    .lvl_we, .lvl_wdata, .ack, .ret, .cpu_lvl, .req_valid, .req_lvl, .req_vector);

  always #(CLK_P/2) clk = ~clk;

  // {mask, expect_valid, expect_source}
  localparam logic [11:0] TBL [8] = '{
    {8'h01, 1'b1, 3'd0}, {8'h06, 1'b1, 3'd1}, {8'h48, 1'b1, 3'd3}, {8'h10, 1'b0, 3'd0},
    {8'h81, 1'b1, 3'd7}, {8'h23, 1'b1, 3'd1}, {8'hC0, 1'b1, 3'd6}, {8'h00, 1'b0, 3'd0}};
  localparam logic [2:0] PR [8] = '{3'd1, 3'd5, 3'd5, 3'd7, 3'd0, 3'd3, 3'd7, 3'd2};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
  endtask

  task automatic cfg(logic [3:0] a, logic [2:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; step(); cfg_we = 0;
  endtask

  task automatic pulse_irq(logic [NSRC-1:0] m);
    irq_req = m; step(); irq_req = '0;
  endtask

  task automatic pulse_trap(logic [3:0] m);
    trap_req = m; step(); trap_req = '0;
  endtask

  task automatic do_ack(); ack = 1; step(); ack = 0; endtask
  task automatic do_ret(); ret = 1; step(); ret = 0; endtask
  task automatic wr_lvl(logic [3:0] v); lvl_we = 1; lvl_wdata = v; step(); lvl_we = 0; endtask

  task automatic prog_all();
    for (int i = 0; i < NSRC; i++) cfg(4'(i), PR[i]);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 cpu_lvl", cpu_lvl, 0);
    check("R1 req_valid", req_valid, 0);
    pulse_irq(8'h10);
    check("R1 reset prio valid", req_valid, 1);
    check("R1 reset prio lvl", req_lvl, 4);

    // table walk: R2, R3, R4
    for (int t = 0; t < 8; t++) begin
      do_reset();
      prog_all();
      pulse_irq(TBL[t][11:4]);
      check("R3 valid", req_valid, TBL[t][3]);
      if (TBL[t][3]) begin
        check("R3 winner lvl", req_lvl, PR[TBL[t][2:0]]);
        check("R4 vector", req_vector, 32'h14 + 2 * TBL[t][2:0]);
      end
    end

    // R4 / R11 alternate table and ignored address
    do_reset(); prog_all();
    cfg(4'd9, 3'd1);
    pulse_irq(8'h01);
    check("R11 ignored addr", req_vector, 32'h14);
    cfg(4'd8, 3'd1);
    check("R4 alt vector", req_vector, 32'h114);

    // R6 trap timing, R5 ranking
    do_reset();
    pulse_trap(4'b1000);
    check("R6 soft not yet", req_valid, 0);
    step();
    check("R6 soft pending", req_valid, 1);
    check("R5 arith vector", req_vector, 32'h0C);
    check("R5 arith lvl", req_lvl, 11);
    do_reset(); prog_all();
    pulse_irq(8'h08);
    pulse_trap(4'b0001);
    check("R6 hard one edge", req_valid, 1);
    check("R5 osc vector", req_vector, 32'h06);
    check("R5 osc lvl", req_lvl, 14);
    pulse_trap(4'b0010);
    check("R5 osc over addr", req_vector, 32'h06);

    // R7 R8 R9 nesting
    do_reset(); prog_all();
    do_ack();
    check("R7 ack no req ignored", cpu_lvl, 0);
    pulse_irq(8'h02);
    do_ack();
    check("R7 cpu raised", cpu_lvl, 5);
    check("R7 pending cleared", req_valid, 0);
    pulse_irq(8'h04);
    check("R2 same level held", req_valid, 0);
    pulse_irq(8'h08);
    check("R3 preempt vector", req_vector, 32'h1A);
    do_ack();
    check("R7 cpu 7", cpu_lvl, 7);
    pulse_trap(4'b0001);
    check("R9 full blocks", req_valid, 0);
    do_ret();
    check("R8 restore 5", cpu_lvl, 5);
    check("R9 trap after pop", req_vector, 32'h06);
    ack = 1; ret = 1; step(); ack = 0; ret = 0;
    check("R8 ret wins over ack", cpu_lvl, 0);
    check("R8 trap still offered", req_vector, 32'h06);
    do_ack();
    check("R7 trap lvl", cpu_lvl, 14);
    do_ret();
    check("R8 back to 0", cpu_lvl, 0);
    check("R8 waiting source", req_vector, 32'h18);
    do_ret();
    check("R8 empty ret ignored", cpu_lvl, 0);

    // R10 level writes
    do_reset(); prog_all();
    wr_lvl(4'd8);
    check("R10 bit3 not set", cpu_lvl, 0);
    wr_lvl(4'd5);
    pulse_irq(8'h02);
    check("R2 equal blocked", req_valid, 0);
    wr_lvl(4'd4);
    check("R2 greater offered", req_valid, 1);
    pulse_trap(4'b0010);
    do_ack();
    check("R7 addr trap lvl", cpu_lvl, 13);
    wr_lvl(4'd6);
    check("R10 bit3 cleared", cpu_lvl, 6);
    cfg(4'd8, 3'd2);
    wr_lvl(4'd1);
    check("R10 nest disable lock", cpu_lvl, 6);
    lvl_we = 1; lvl_wdata = 4'd0; ret = 1; step(); lvl_we = 0; ret = 0;
    check("R10 ret precedence", cpu_lvl, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule